// File: doc/BRIEF.md
# Masked CRC Wake-Frame Filter

This block watches a received byte stream and decides, once per frame, whether the frame is a programmed wake-up frame. Software supplies a 128-bit byte mask, an expected 16-bit CRC and a 48-bit station address. The block runs a CRC-16 over only those frame bytes whose mask bit is set, among the first 128 bytes counted from the start-of-frame byte. It compares the result with the expected value and, if enabled, also requires the destination address to qualify.

The address qualifier passes on any of three conditions: the destination equals the programmed address, the destination is any multicast address (if that is enabled), or the destination is broadcast (if that is enabled). The decision is taken on the end-of-frame beat. It needs the good-frame input, and a hit sets a sticky wake status that only reset clears.

Top module: `wake_crc_filter`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `wake_frame_rcvd` is 0.
- R2: The CRC-16 uses polynomial 0x8005 and initial value 0xFFFF. Each byte is fed bit 0 first, with feedback = crc[15] xor data bit; crc is shifted left and xored with 0x8005 when the feedback is 1. There is no final inversion. A frame whose masked CRC equals `cfg_crc` sets `wake_frame_rcvd` on the clock edge that takes the end-of-frame beat, so the status is visible in the next cycle. A mismatch does not set it.
- R3: Mask bit i selects frame byte i, where the byte on the `rx_sof` beat is byte 0. A change to an unselected byte does not change the result. A change to a selected byte does.
- R4: Bytes at index 128 and above never enter the CRC, whatever the mask holds.
- R5: A frame that ends before the highest selected index is judged on the selected bytes that arrived. A one-byte frame, with `rx_sof` and `rx_eof` on the same beat, is valid.
- R6: Once set, `wake_frame_rcvd` stays set through later frames, matching or not, until reset.
- R7: With `cfg_filter_en` low, no frame sets the status.
- R8: With `rx_good` low on the end-of-frame beat, the frame does not set the status.
- R9: With `cfg_addr_en` low, the CRC match alone decides, whatever the destination bytes are.
- R10: With `cfg_addr_en` high, a destination whose six bytes equal `cfg_addr` passes the address check. Byte 0 on the wire is compared with `cfg_addr[47:40]`, and byte 5 with `cfg_addr[7:0]`.
- R11: With `cfg_addr_en` and `cfg_mcast_en` high, any destination with bit 0 of byte 0 set passes. With `cfg_mcast_en` low, such a destination passes only through R10 or R12.
- R12: With `cfg_addr_en` and `cfg_bcast_en` high, a destination of six 0xFF bytes passes.
- R13: With `cfg_addr_en` high, a frame whose destination passes none of R10 to R12 does not set the status. This includes a frame shorter than six bytes, unless R11 applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_sof | input | 1 | The current byte is the first byte of a frame |
| rx_eof | input | 1 | The current byte is the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_good | input | 1 | The frame is error free; read on the end-of-frame beat |
| cfg_filter_en | input | 1 | Filter enable |
| cfg_addr_en | input | 1 | Require the destination-address qualifier |
| cfg_mcast_en | input | 1 | Accept any multicast destination |
| cfg_bcast_en | input | 1 | Accept the broadcast destination |
| cfg_byte_mask | input | 128 | Bit i selects frame byte i for the CRC |
| cfg_crc | input | 16 | Expected CRC-16 |
| cfg_addr | input | 48 | Programmed destination; bits 47:40 are the first byte |
| wake_frame_rcvd | output | 1 | Sticky wake-frame status |

## Verification
The only result is the status bit. It is registered on the edge that takes the end-of-frame beat, so a frame's effect is due one cycle after its last byte is driven. The bench drives every beat on the falling edge. After the last byte it waits for one rising edge and reads the status on the following falling edge. For a rejected frame the same sample point shows the bit still clear, and for the sticky case it is sampled again after further frames and idle cycles. Expected CRC values come from a bit-serial model in the bench, run over the mask and the frame buffer that the bench built.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          CRC_W      = 16;
    localparam int          ADDR_BYTES = 6;
    localparam logic [15:0] CRC_POLY   = 16'h8005;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;

    typedef struct packed {
        logic complete;   // all six destination bytes present
        logic exact;      // destination equals the programmed address
        logic group;      // group bit of the first destination byte
        logic all_ones;   // six 0xFF bytes
    } dest_class_t;

    function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] cur,
                                                    input logic [BYTE_W-1:0] din);
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = cur;
        for (int b = 0; b < BYTE_W; b++) begin
            fb  = acc[CRC_W-1] ^ din[b];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return acc;
    endfunction

endpackage

// File: rtl/wkf_byte_counter.sv
module wkf_byte_counter #(
    parameter int MASK_BYTES = 128,
    localparam int IDX_W     = $clog2(MASK_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             frame_beat,
    output logic [IDX_W-1:0] cur_idx,
    output logic             in_window,
    output logic [IDX_W-1:0] idx_q
);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(MASK_BYTES);

    logic in_frame_q;

    assign frame_beat = rx_valid && (rx_sof || in_frame_q);
    assign cur_idx    = rx_sof ? '0 : idx_q;
    assign in_window  = cur_idx < IDX_LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
        end else if (frame_beat) begin
            in_frame_q <= !rx_eof;
            if (rx_eof)
                idx_q <= '0;
            else if (in_window)
                idx_q <= cur_idx + 1'b1;
            else
                idx_q <= IDX_LIMIT;
        end
    end
endmodule

// File: rtl/wkf_crc_accum.sv
module wkf_crc_accum
    import wkf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_beat,
    input  logic              rx_sof,
    input  logic              byte_sel,
    input  logic [BYTE_W-1:0] rx_data,
    output logic [CRC_W-1:0]  crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    assign crc_base = rx_sof ? CRC_SEED : crc_q;
    assign crc_next = byte_sel ? crc16_step(crc_base, rx_data) : crc_base;

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= CRC_SEED;
        else if (frame_beat)
            crc_q <= crc_next;
    end
endmodule

// File: rtl/wkf_addr_class.sv
module wkf_addr_class
    import wkf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_beat,
    input  logic [IDX_W-1:0]             cur_idx,
    input  logic [BYTE_W-1:0]            rx_data,
    input  logic [ADDR_BYTES*BYTE_W-1:0] cfg_addr,
    output dest_class_t                  cls
);
    logic [BYTE_W-1:0] dest_q [ADDR_BYTES];
    logic [BYTE_W-1:0] dest_v [ADDR_BYTES];
    logic [ADDR_BYTES-1:0] eq_v;
    logic [ADDR_BYTES-1:0] ff_v;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_dest
        logic hit_here;
        assign hit_here  = frame_beat && (cur_idx == IDX_W'(g));
        assign dest_v[g] = hit_here ? rx_data : dest_q[g];
        assign eq_v[g]   = dest_v[g] == cfg_addr[(ADDR_BYTES-1-g)*BYTE_W +: BYTE_W];
        assign ff_v[g]   = &dest_v[g];

        always_ff @(posedge clk) begin
            if (rst)
                dest_q[g] <= '0;
            else if (hit_here)
                dest_q[g] <= rx_data;
        end
    end

    always_comb begin
        cls.complete = cur_idx >= IDX_W'(ADDR_BYTES - 1);
        cls.exact    = cls.complete && (&eq_v);
        cls.all_ones = cls.complete && (&ff_v);
        cls.group    = dest_v[0][0];
    end
endmodule

// File: rtl/wake_crc_filter.sv
module wake_crc_filter
    import wkf_pkg::*;
#(
    parameter int MASK_BYTES = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic                  rx_eof,
    input  logic [7:0]            rx_data,
    input  logic                  rx_good,
    input  logic                  cfg_filter_en,
    input  logic                  cfg_addr_en,
    input  logic                  cfg_mcast_en,
    input  logic                  cfg_bcast_en,
    input  logic [MASK_BYTES-1:0] cfg_byte_mask,
    input  logic [15:0]           cfg_crc,
    input  logic [47:0]           cfg_addr,
    output logic                  wake_frame_rcvd
);
    localparam int IDX_W = $clog2(MASK_BYTES) + 1;

    logic             frame_beat;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] idx_q;
    logic             in_window;
    logic             byte_sel;
    logic [CRC_W-1:0] crc_next;
    dest_class_t      cls;
    logic             addr_ok;
    logic             frame_hit;

    wkf_byte_counter #(.MASK_BYTES(MASK_BYTES)) u_cnt (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .frame_beat(frame_beat), .cur_idx(cur_idx), .in_window(in_window), .idx_q(idx_q)
    );

    assign byte_sel = frame_beat && in_window && cfg_byte_mask[cur_idx[IDX_W-2:0]];

    wkf_crc_accum u_crc (
        .clk(clk), .rst(rst), .frame_beat(frame_beat), .rx_sof(rx_sof),
        .byte_sel(byte_sel), .rx_data(rx_data), .crc_next(crc_next)
    );

    wkf_addr_class #(.IDX_W(IDX_W)) u_addr (
        .clk(clk), .rst(rst), .frame_beat(frame_beat), .cur_idx(cur_idx),
        .rx_data(rx_data), .cfg_addr(cfg_addr), .cls(cls)
    );

    assign addr_ok   = cls.exact
                     || (cfg_mcast_en && cls.group)
                     || (cfg_bcast_en && cls.all_ones);

    assign frame_hit = frame_beat && rx_eof && rx_good && cfg_filter_en
                     && (crc_next == cfg_crc)
                     && (!cfg_addr_en || addr_ok);

    always_ff @(posedge clk) begin
        if (rst)
            wake_frame_rcvd <= 1'b0;
        else if (frame_hit)
            wake_frame_rcvd <= 1'b1;
    end
endmodule

// File: rtl/wkf_checker.sv
module wkf_checker #(
    parameter int IDX_W = 8,
    parameter int LIMIT = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             rx_good,
    input logic             cfg_filter_en,
    input logic             wake_frame_rcvd,
    input logic [IDX_W-1:0] idx_q
);
    AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !wake_frame_rcvd); // R1
    AST_SET_ON_EOF: assert property (@(posedge clk) disable iff (rst) $rose(wake_frame_rcvd) |-> $past(rx_valid && rx_eof)); // R2
    AST_IDX_BOUNDED: assert property (@(posedge clk) disable iff (rst) idx_q <= IDX_W'(LIMIT)); // R4
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst) wake_frame_rcvd |=> wake_frame_rcvd); // R6
    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) $rose(wake_frame_rcvd) |-> $past(cfg_filter_en)); // R7
    AST_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst) $rose(wake_frame_rcvd) |-> $past(rx_good)); // R8
endmodule

bind wake_crc_filter wkf_checker #(.IDX_W(IDX_W), .LIMIT(MASK_BYTES)) u_wkf_checker (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_good(rx_good),
    .cfg_filter_en(cfg_filter_en), .wake_frame_rcvd(wake_frame_rcvd), .idx_q(idx_q)
);

// File: tb/wake_crc_filter_bench.sv
module wake_crc_filter_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         rx_valid, rx_sof, rx_eof, rx_good;
    logic [7:0]   rx_data;
    logic         cfg_filter_en, cfg_addr_en, cfg_mcast_en, cfg_bcast_en;
    logic [127:0] cfg_byte_mask;
    logic [15:0]  cfg_crc;
    logic [47:0]  cfg_addr;
    logic         wake_frame_rcvd;

    int checks = 0;
    int errors = 0;
    logic [7:0] fbuf [0:255];

    always #10 clk = ~clk;

    wake_crc_filter u_wake_crc_filter (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_good(rx_good), .cfg_filter_en(cfg_filter_en),
        .cfg_addr_en(cfg_addr_en), .cfg_mcast_en(cfg_mcast_en), .cfg_bcast_en(cfg_bcast_en),
        .cfg_byte_mask(cfg_byte_mask), .cfg_crc(cfg_crc), .cfg_addr(cfg_addr),
        .wake_frame_rcvd(wake_frame_rcvd)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wake_frame_rcvd=%b expected %b", tag, act, exp);
        end
    endtask

    // bench model of the CRC over selected bytes of fbuf[0:len-1]
    function automatic logic [15:0] model_crc(input int len);
        logic [15:0] r = 16'hFFFF;
        for (int i = 0; i < len && i < 128; i++) begin
            if (cfg_byte_mask[i]) begin
                for (int b = 0; b < 8; b++) begin
                    if (r[15] != fbuf[i][b]) r = (r << 1) ^ 16'h8005;
                    else                     r = r << 1;
                end
            end
        end
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; rx_data = '0;
        cfg_filter_en = 1; cfg_addr_en = 0; cfg_mcast_en = 0; cfg_bcast_en = 0;
        cfg_addr = 48'h02_A1_B2_C3_D4_E5;
        cfg_byte_mask = '0;
        for (int i = 10; i < 60; i += 3) cfg_byte_mask[i] = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) fbuf[i] = 8'((i * 37 + seed * 11 + 5) & 255);
        for (int i = 0; i < 6; i++) fbuf[i] = cfg_addr[(5 - i) * 8 +: 8] ^ 8'h10; // non-matching unicast
    endtask

    // drive a frame; return with status ready to sample
    task automatic send(input int len, input logic good);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = fbuf[i]; rx_good = (i == len - 1) ? good : 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; rx_data = '0;
        cfg_filter_en = 1; cfg_addr_en = 0; cfg_mcast_en = 0; cfg_bcast_en = 0;
        cfg_byte_mask = '0; cfg_crc = '0; cfg_addr = '0;
        repeat (3) @(negedge clk);
        check("R1 during reset", wake_frame_rcvd, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", wake_frame_rcvd, 1'b0);
    endtask

    task automatic t_basic();
        do_reset(); fill(64, 1); cfg_crc = model_crc(64);
        send(64, 1); check("R2 match", wake_frame_rcvd, 1'b1);
        do_reset(); fill(64, 1); cfg_crc = model_crc(64) ^ 16'h0001;
        send(64, 1); check("R2 mismatch", wake_frame_rcvd, 1'b0);
    endtask

    task automatic t_mask();
        do_reset(); fill(64, 2); cfg_crc = model_crc(64);
        fbuf[11] = ~fbuf[11]; fbuf[63] = 8'h00;
        send(64, 1); check("R3 unselected byte changed", wake_frame_rcvd, 1'b1);
        do_reset(); fill(64, 2); cfg_crc = model_crc(64);
        fbuf[13] = ~fbuf[13];
        send(64, 1); check("R3 selected byte changed", wake_frame_rcvd, 1'b0);
        do_reset(); cfg_byte_mask = 128'h1; fill(64, 3); cfg_crc = model_crc(64);
        fbuf[0] = ~fbuf[0];
        send(64, 1); check("R3 byte 0 selected", wake_frame_rcvd, 1'b0);
    endtask

    task automatic t_beyond();
        do_reset(); cfg_byte_mask = '1; fill(200, 4); cfg_crc = model_crc(200);
        fbuf[128] = ~fbuf[128]; fbuf[170] = ~fbuf[170];
        send(200, 1); check("R4 bytes past 127 ignored", wake_frame_rcvd, 1'b1);
        do_reset(); cfg_byte_mask = '1; fill(200, 4); cfg_crc = model_crc(200);
        fbuf[127] = ~fbuf[127];
        send(200, 1); check("R4 byte 127 included", wake_frame_rcvd, 1'b0);
    endtask

    task automatic t_short();
        do_reset(); fill(30, 5); cfg_crc = model_crc(30);
        send(30, 1); check("R5 short frame", wake_frame_rcvd, 1'b1);
        do_reset(); cfg_byte_mask = 128'h1; fbuf[0] = 8'h5A; cfg_crc = model_crc(1);
        send(1, 1); check("R5 one-byte frame", wake_frame_rcvd, 1'b1);
    endtask

    task automatic t_sticky();
        do_reset(); fill(40, 6); cfg_crc = model_crc(40);
        send(40, 1);
        fill(40, 7); fbuf[10] = ~fbuf[10]; cfg_crc = ~model_crc(40);
        send(40, 1);
        repeat (5) @(negedge clk);
        check("R6 sticky after mismatch", wake_frame_rcvd, 1'b1);
    endtask

    task automatic t_enable_good();
        do_reset(); cfg_filter_en = 0; fill(40, 8); cfg_crc = model_crc(40);
        send(40, 1); check("R7 filter disabled", wake_frame_rcvd, 1'b0);
        do_reset(); fill(40, 8); cfg_crc = model_crc(40);
        send(40, 0); check("R8 bad frame", wake_frame_rcvd, 1'b0);
    endtask

    task automatic t_address();
        do_reset(); fill(40, 9); cfg_crc = model_crc(40);
        send(40, 1); check("R9 address check off", wake_frame_rcvd, 1'b1);
        do_reset(); cfg_addr_en = 1; fill(40, 9);
        for (int i = 0; i < 6; i++) fbuf[i] = cfg_addr[(5 - i) * 8 +: 8];
        cfg_crc = model_crc(40);
        send(40, 1); check("R10 exact destination", wake_frame_rcvd, 1'b1);
        do_reset(); cfg_addr_en = 1; cfg_mcast_en = 1; cfg_bcast_en = 1; fill(40, 9);
        cfg_crc = model_crc(40);
        send(40, 1); check("R13 unicast mismatch", wake_frame_rcvd, 1'b0);
        do_reset(); cfg_addr_en = 1; cfg_mcast_en = 1; fill(40, 10);
        fbuf[0] = 8'h33; cfg_crc = model_crc(40);
        send(40, 1); check("R11 any multicast on", wake_frame_rcvd, 1'b1);
        do_reset(); cfg_addr_en = 1; fill(40, 10);
        fbuf[0] = 8'h33; cfg_crc = model_crc(40);
        send(40, 1); check("R11 any multicast off", wake_frame_rcvd, 1'b0);
        do_reset(); cfg_addr_en = 1; cfg_bcast_en = 1; fill(40, 11);
        for (int i = 0; i < 6; i++) fbuf[i] = 8'hFF;
        cfg_crc = model_crc(40);
        send(40, 1); check("R12 broadcast on", wake_frame_rcvd, 1'b1);
        do_reset(); cfg_addr_en = 1; fill(40, 11);
        for (int i = 0; i < 6; i++) fbuf[i] = 8'hFF;
        cfg_crc = model_crc(40);
        send(40, 1); check("R12 broadcast off", wake_frame_rcvd, 1'b0);
        do_reset(); cfg_addr_en = 1; cfg_bcast_en = 1; cfg_byte_mask = 128'h1;
        for (int i = 0; i < 4; i++) fbuf[i] = 8'hFF;
        cfg_crc = model_crc(4);
        send(4, 1); check("R13 short destination", wake_frame_rcvd, 1'b0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_beyond();
        t_short();
        t_sticky();
        t_enable_good();
        t_address();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule